// File: doc/BRIEF.md
# Handshaked Register Slave for a Two-Direction Mapper

This block is the software-visible register file of a mapper with an insert half and an extract half. A master reaches it over a narrow bus: a select line, a read/write line (high means read), a 4-bit address, an 8-bit write bus, an 8-bit read bus, an acknowledge and an interrupt request. The slave may run on a different clock from the master. Select passes through a synchronizer. Each assertion of select performs exactly one access, and acknowledge stays high until select is withdrawn, which completes a four-phase handshake.

Each half has an enable bit, a sync-status bit, a two-bit interrupt status with matching enables, and a two-bit overhead field. On the insert side the overhead field is written by software. On the extract side it is read-only and follows an input port. Two 5-bit FIFO threshold marks complete the map. The datapath logic that raises status and events is outside this block; its outputs reach the block as input ports, and the control fields are driven back out as output ports. Several such slaves can share one master, because their read data and acknowledge outputs are OR-combined.

Top module: `regslv_top`

## Requirements
- R1: After a synchronous reset, acknowledge, read data, the interrupt request and every register and control output are 0.
- R2: Register map (address: field). 0: insert enable (bit 0). 1: insert sync status (bit 0, read-only). 2: insert interrupt status. 3: insert interrupt enable. 4: insert overhead (bits 1:0). 5 to 9: the same five registers for the extract half, except that 9 is read-only and returns the extract overhead input. 10 (hex A): high mark (bits 4:0). 11 (hex B): low mark (bits 4:0). Writable fields read back what was written, and the enable, overhead and mark fields appear on their output ports.
- R3: Acknowledge rises on the third rising clock edge after select is first seen high (two synchronizer stages, then the access). It stays high while select is held, and it falls once the synchronized select is low.
- R4: While acknowledge is low, the read data is 0, so that several slaves can be OR-merged.
- R5: Each assertion of select performs exactly one write or one read-clear. An event that arrives while acknowledge is held is not cleared by that same access.
- R6: Interrupt status bits (bit 1 = FIFO fault, bit 0 = framing fault) are set by the event inputs. They are returned and then cleared by a read of their address, and they ignore writes.
- R7: The interrupt request is 1 exactly when some interrupt status bit is 1 and its enable bit at the same position is 1.
- R8: An event that arrives on the same edge as the read-clear of its register stays pending.
- R9: Register bits outside the defined fields read as 0, and writes to read-only registers or to addresses 12 to 15 change nothing; those addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Access select from the master, may be asynchronous |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not acknowledging |
| ack | output | 1 | Acknowledge, held until select drops |
| irq | output | 1 | Interrupt request |
| ins_sync_st | input | 1 | Insert half sync status |
| ext_sync_st | input | 1 | Extract half sync status |
| ins_evt | input | 2 | Insert event pulses (bit 1 FIFO, bit 0 framing) |
| ext_evt | input | 2 | Extract event pulses (bit 1 FIFO, bit 0 framing) |
| ext_oh_in | input | 2 | Overhead bits captured by the extract half |
| ins_enable | output | 1 | Insert enable field |
| ext_enable | output | 1 | Extract enable field |
| ins_oh | output | 2 | Insert overhead field |
| mark_hi | output | 5 | FIFO high mark |
| mark_lo | output | 5 | FIFO low mark |

## Verification
The hardest case to reach is an event that lands on exactly the edge where a read-clear takes effect, because the access begins only after select has crossed the synchronizer. The bench counts edges from the moment it raises select and pulses the event input so that it is high on the third edge. It then reads the register again and expects the bit to still be set. A second directed case raises an event while acknowledge is held and checks that the bit survives the access. The rest of the stimulus consists of random reads, writes, event pulses and status changes checked against a bench model.

// File: rtl/regslv_pkg.sv
package regslv_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_INS_CTL  = 4'h0,
        A_INS_STS  = 4'h1,
        A_INS_IS   = 4'h2,
        A_INS_IE   = 4'h3,
        A_INS_OH   = 4'h4,
        A_EXT_CTL  = 4'h5,
        A_EXT_STS  = 4'h6,
        A_EXT_IS   = 4'h7,
        A_EXT_IE   = 4'h8,
        A_EXT_OH   = 4'h9,
        A_MARK_HI  = 4'hA,
        A_MARK_LO  = 4'hB
    } reg_addr_e;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HOLD = 1'b1
    } hs_state_e;

    // Interrupt status address of half h (0 = insert, 1 = extract)
    function automatic reg_addr_e is_addr_of(input int h);
        return (h == 0) ? A_INS_IS : A_EXT_IS;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
    import regslv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_s,
    output logic fire,
    output logic rel,
    output logic ack
);
    hs_state_e state;

    assign fire = (state == HS_IDLE) && sel_s;
    assign rel  = (state == HS_HOLD) && !sel_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            ack   <= 1'b0;
        end else if (fire) begin
            state <= HS_HOLD;
            ack   <= 1'b1;
        end else if (rel) begin
            state <= HS_IDLE;
            ack   <= 1'b0;
        end
    end

    assert_ack_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (ack && sel_s) |=> ack);
    assert_ack_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (ack && !sel_s) |=> !ack);
    assert_ack_needs_sel_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(sel_s));
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int EVT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic             clr,
    output logic [EVT_W-1:0] is_q
);
    always_ff @(posedge clk) begin
        if (rst)      is_q <= '0;
        else if (clr) is_q <= evt;
        else          is_q <= is_q | evt;
    end

    assert_event_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((is_q & $past(evt)) == $past(evt)));
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && evt == '0) |=> (is_q == '0));
endmodule

// File: rtl/regslv_top.sv
module regslv_top
    import regslv_pkg::*;
#(
    parameter int MARK_W      = 5,
    parameter int OH_W        = 2,
    parameter int EVT_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              irq,
    input  logic              ins_sync_st,
    input  logic              ext_sync_st,
    input  logic [EVT_W-1:0]  ins_evt,
    input  logic [EVT_W-1:0]  ext_evt,
    input  logic [OH_W-1:0]   ext_oh_in,
    output logic              ins_enable,
    output logic              ext_enable,
    output logic [OH_W-1:0]   ins_oh,
    output logic [MARK_W-1:0] mark_hi,
    output logic [MARK_W-1:0] mark_lo
);
    localparam int HALVES = 2;

    logic sel_s, fire, rel, wr, rdc;
    logic [EVT_W-1:0] ie_q  [HALVES];
    logic [EVT_W-1:0] is_q  [HALVES];
    logic [EVT_W-1:0] evt_v [HALVES];
    logic [DATA_W-1:0] rd_val, rdata_q;
    reg_addr_e a_e;

    assign a_e      = reg_addr_e'(addr);
    assign evt_v[0] = ins_evt;
    assign evt_v[1] = ext_evt;

    hs_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .d(sel), .q(sel_s)
    );

    hs_ctrl i_ctrl (
        .clk(clk), .rst(rst), .sel_s(sel_s),
        .fire(fire), .rel(rel), .ack(ack)
    );

    assign wr  = fire && !rd_nwr;
    assign rdc = fire && rd_nwr;

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            logic clr_h;
            assign clr_h = rdc && (a_e == is_addr_of(h));
            irq_bank #(.EVT_W(EVT_W)) i_bank (
                .clk(clk), .rst(rst), .evt(evt_v[h]),
                .clr(clr_h), .is_q(is_q[h])
            );
        end
    endgenerate

    // Writable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ins_enable <= 1'b0;
            ext_enable <= 1'b0;
            ie_q[0]    <= '0;
            ie_q[1]    <= '0;
            ins_oh     <= '0;
            mark_hi    <= '0;
            mark_lo    <= '0;
        end else if (wr) begin
            case (a_e)
                A_INS_CTL: ins_enable <= wdata[0];
                A_EXT_CTL: ext_enable <= wdata[0];
                A_INS_IE:  ie_q[0]    <= wdata[EVT_W-1:0];
                A_EXT_IE:  ie_q[1]    <= wdata[EVT_W-1:0];
                A_INS_OH:  ins_oh     <= wdata[OH_W-1:0];
                A_MARK_HI: mark_hi    <= wdata[MARK_W-1:0];
                A_MARK_LO: mark_lo    <= wdata[MARK_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (a_e)
            A_INS_CTL: rd_val = DATA_W'(ins_enable);
            A_INS_STS: rd_val = DATA_W'(ins_sync_st);
            A_INS_IS:  rd_val = DATA_W'(is_q[0]);
            A_INS_IE:  rd_val = DATA_W'(ie_q[0]);
            A_INS_OH:  rd_val = DATA_W'(ins_oh);
            A_EXT_CTL: rd_val = DATA_W'(ext_enable);
            A_EXT_STS: rd_val = DATA_W'(ext_sync_st);
            A_EXT_IS:  rd_val = DATA_W'(is_q[1]);
            A_EXT_IE:  rd_val = DATA_W'(ie_q[1]);
            A_EXT_OH:  rd_val = DATA_W'(ext_oh_in);
            A_MARK_HI: rd_val = DATA_W'(mark_hi);
            A_MARK_LO: rd_val = DATA_W'(mark_lo);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_q <= '0;
        else if (rdc)  rdata_q <= rd_val;
        else if (rel)  rdata_q <= '0;
    end

    assign rdata = rdata_q;
    assign irq   = |(is_q[0] & ie_q[0]) || |(is_q[1] & ie_q[1]);

    assert_rdata_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !ack |-> (rdata == '0));
    assert_single_access_R5: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(ack)) |-> !fire);
endmodule

// File: tb/test_regslv_top.sv
module test_regslv_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1;
    logic sel = 0, rd_nwr = 0;
    logic [3:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic ack, irq;
    logic ins_sync_st = 0, ext_sync_st = 0;
    logic [1:0] ins_evt = 0, ext_evt = 0, ext_oh_in = 0;
    logic ins_enable, ext_enable;
    logic [1:0] ins_oh;
    logic [4:0] mark_hi, mark_lo;

    int checks = 0, failures = 0, cycles = 0;
    logic [7:0] mdl [16];
    logic [1:0] pend [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    regslv_top i_regslv_top (
        .clk(clk), .rst(rst), .sel(sel), .rd_nwr(rd_nwr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack(ack), .irq(irq),
        .ins_sync_st(ins_sync_st), .ext_sync_st(ext_sync_st),
        .ins_evt(ins_evt), .ext_evt(ext_evt), .ext_oh_in(ext_oh_in),
        .ins_enable(ins_enable), .ext_enable(ext_enable), .ins_oh(ins_oh),
        .mark_hi(mark_hi), .mark_lo(mark_lo)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wmask(input logic [3:0] a);
        case (a)
            4'h0, 4'h5: return 8'h01;
            4'h3, 4'h8, 4'h4: return 8'h03;
            4'hA, 4'hB: return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'h1: return {7'b0, ins_sync_st};
            4'h6: return {7'b0, ext_sync_st};
            4'h2: return {6'b0, pend[0]};
            4'h7: return {6'b0, pend[1]};
            4'h9: return {6'b0, ext_oh_in};
            default: return mdl[a];
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(pend[0] & mdl[3][1:0]) || |(pend[1] & mdl[8][1:0]);
    endfunction

    task automatic access(input logic rd, input logic [3:0] a, input logic [7:0] d,
                          output logic [7:0] q, output int lat);
        @(negedge clk);
        addr = a; rd_nwr = rd; wdata = d; sel = 1; lat = 0;
        while (!ack && lat < 20) begin @(negedge clk); lat++; end
        q = rdata;
        @(negedge clk);
        sel = 0;
        for (int k = 0; k < 20 && ack; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] q; int lat;
        access(0, a, d, q, lat);
        mdl[a] = d & wmask(a);
    endtask

    task automatic do_read(input logic [3:0] a, input string req);
        logic [7:0] q, e; int lat;
        e = exp_read(a);
        access(1, a, 8'h00, q, lat);
        check(req, q, e);
        if (a == 4'h2) pend[0] = 2'b00;
        if (a == 4'h7) pend[1] = 2'b00;
    endtask

    task automatic pulse(input int h, input logic [1:0] b);
        @(negedge clk);
        if (h == 0) ins_evt = b; else ext_evt = b;
        @(negedge clk);
        ins_evt = 0; ext_evt = 0;
        pend[h] = pend[h] | b;
    endtask

    initial begin
        while (cycles < 150000) begin @(posedge clk); cycles++; end
        failures++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] q; int lat; int unsigned r;
        r = $urandom(32'h5eed);
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        pend[0] = 0; pend[1] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 ack", {7'b0, ack}, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 outs", {ins_enable, ext_enable, ins_oh, 4'b0}, 8'h00);
        check("R1 marks", {mark_hi, 3'b0}, 8'h00);
        for (int a = 0; a < 16; a++) do_read(4'(a), "R1 reg");

        // R3 latency and hold
        @(negedge clk);
        addr = 4'hA; rd_nwr = 0; wdata = 8'hFF; sel = 1; lat = 0;
        while (!ack && lat < 20) begin @(negedge clk); lat++; end
        check("R3 latency", 8'(lat), 8'd3);
        repeat (6) @(negedge clk);
        check("R3 held", {7'b0, ack}, 8'h01);
        check("R4 write rdata", rdata, 8'h00);
        sel = 0;
        @(negedge clk); @(negedge clk);
        check("R3 still high", {7'b0, ack}, 8'h01);
        @(negedge clk);
        check("R3 dropped", {7'b0, ack}, 8'h00);
        mdl[10] = 8'h1F;
        check("R2 mark_hi port", {3'b0, mark_hi}, 8'h1F);

        // R2 / R9 directed
        do_write(4'h0, 8'hFF); do_write(4'h5, 8'hFE);
        do_write(4'h4, 8'hFE); do_write(4'hB, 8'hE5);
        check("R2 ins_enable", {7'b0, ins_enable}, 8'h01);
        check("R2 ext_enable", {7'b0, ext_enable}, 8'h00);
        check("R2 ins_oh", {6'b0, ins_oh}, 8'h02);
        check("R2 mark_lo", {3'b0, mark_lo}, 8'h05);
        ext_oh_in = 2'b11; ins_sync_st = 1;
        do_write(4'h9, 8'h00); do_write(4'h1, 8'h00); do_write(4'hC, 8'hFF);
        do_read(4'h9, "R9 ro oh"); do_read(4'h1, "R9 ro sts");
        do_read(4'hC, "R9 hole"); do_read(4'h0, "R9 unused bits");

        // R6 / R7 interrupts
        do_write(4'h3, 8'h02);
        pulse(0, 2'b01);
        @(negedge clk);
        check("R7 masked", {7'b0, irq}, {7'b0, exp_irq()});
        pulse(0, 2'b10);
        @(negedge clk);
        check("R7 enabled", {7'b0, irq}, 8'h01);
        do_write(4'h2, 8'h00);
        do_read(4'h2, "R6 read returns");
        do_read(4'h2, "R6 cleared");
        check("R7 after clear", {7'b0, irq}, 8'h00);

        // R5 event during held ack survives
        pulse(1, 2'b10);
        @(negedge clk);
        addr = 4'h7; rd_nwr = 1; sel = 1; lat = 0;
        while (!ack && lat < 20) begin @(negedge clk); lat++; end
        check("R5 read value", rdata, 8'h02);
        ext_evt = 2'b01; @(negedge clk); ext_evt = 0;
        repeat (3) @(negedge clk);
        sel = 0;
        for (int k = 0; k < 20 && ack; k++) @(negedge clk);
        @(negedge clk);
        pend[1] = 2'b01;
        do_read(4'h7, "R5 kept");

        // R8 event on the clearing edge
        pulse(0, 2'b10);
        @(negedge clk);
        addr = 4'h2; rd_nwr = 1; sel = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); ins_evt = 2'b01;
        @(posedge clk);
        @(negedge clk); ins_evt = 0;
        check("R8 ack", {7'b0, ack}, 8'h01);
        check("R8 read value", rdata, 8'h02);
        sel = 0;
        for (int k = 0; k < 20 && ack; k++) @(negedge clk);
        @(negedge clk);
        pend[0] = 2'b01;
        do_read(4'h2, "R8 kept");

        // random mix (R2 R6 R7 R9)
        for (int i = 0; i < 300; i++) begin
            r = $urandom % 4;
            if (r == 0) do_write(4'($urandom), 8'($urandom));
            else if (r == 1) do_read(4'($urandom), "R2 random read");
            else if (r == 2) pulse(int'($urandom % 2), 2'($urandom));
            else begin
                ins_sync_st = 1'($urandom); ext_sync_st = 1'($urandom);
                ext_oh_in = 2'($urandom);
                @(negedge clk);
            end
            check("R7 random irq", {7'b0, irq}, {7'b0, exp_irq()});
            check("R4 idle rdata", rdata, 8'h00);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule